// File: doc/BRIEF.md
# I2C Target Byte Data Engine

This block is the byte-level data path of an I2C target that has already matched its address. It runs on the system clock. SCL and SDA pass through two-flop synchronizers, and edges and bus conditions are found in the system-clock domain. The block pulls SDA low through an open-drain enable. Two pulses start a transfer once the address phase is done: `rx_begin` for a host write and `tx_begin` for a host read.

In receive mode, bits are sampled MSB first on SCL rising edges into a shift register. A finished byte goes to a single holding buffer, which software drains through `sw_rd`. If a byte finishes while the buffer is still unread, that byte stays in the shift register and the overrun flag is raised. While overrun is set, every byte is refused. Reading the buffer then hands the held byte over.

In transmit mode, the byte that software wrote into the buffer is shifted out MSB first. SDA changes only while SCL is low. The host's answer in the ninth clock decides what happens next: an acknowledge loads the next byte, and a refusal makes the target let go of the bus and go idle. A START or STOP seen while a transfer is active ends that transfer at once.

States of the sequencer: `ST_IDLE`, `ST_RX_BIT`, `ST_RX_ACK`, `ST_TX_BIT`, `ST_TX_ACK`. Transitions:
- `ST_IDLE` goes to `ST_RX_BIT` on `rx_begin`, and to `ST_TX_BIT` on `tx_begin`.
- `ST_RX_BIT` goes to `ST_RX_ACK` on the SCL fall after eight data bits.
- `ST_RX_ACK` goes back to `ST_RX_BIT` on the ninth SCL fall.
- `ST_TX_BIT` goes to `ST_TX_ACK` on the eighth SCL fall.
- `ST_TX_ACK` goes to `ST_TX_BIT` when the host acknowledged, and to `ST_IDLE` when it refused.
- Any active state goes to `ST_IDLE` on a START or STOP.

Top module: `i2c_target_data_engine`

## Requirements
- R1: After reset, `busy`, `rx_rdy`, `rx_ovr`, `irq` and `sda_oe` are 0, and `rd_data` is 0x00.
- R2: In receive mode, the first SCL rise of a byte sets `busy`. Data bits are sampled from SDA on SCL rises, most significant bit first.
- R3: When the eighth bit arrives and the buffer is empty, the byte appears on `rd_data` and `rx_rdy` is set.
- R4: When not in overrun, the target drives `ack_bit` onto SDA (0 pulls low) from the eighth SCL fall until the ninth SCL fall. `busy` clears on the ninth SCL fall.
- R5: When a byte completes while `rx_rdy` is still set, `rx_ovr` is set and `rd_data` keeps the earlier byte.
- R6: While `rx_ovr` is set, incoming bits are not shifted in, and SDA is released in every acknowledge slot whatever `ack_bit` holds.
- R7: A `sw_rd` pulse without overrun clears `rx_rdy`. A `sw_rd` pulse during overrun puts the held byte on `rd_data`, keeps `rx_rdy` at 1 and clears `rx_ovr`. Reception then resumes normally.
- R8: In transmit mode, the buffer byte is driven MSB first, and SDA only starts being pulled low while SCL is low.
- R9: A `sw_wr` pulse loads `sw_wdata` into the buffer only while `busy` is 0. In transmit mode, `busy` is set by the first SCL rise of a byte and cleared by the eighth SCL fall.
- R10: A host acknowledge (SDA low at the ninth SCL rise) makes the target drive the current buffer byte next. A refusal releases SDA and returns to idle, after which further SCL pulses drive nothing.
- R11: A START or STOP during a transfer clears `busy`, releases SDA and returns to idle, leaving `rx_rdy`, `rx_ovr` and `rd_data` unchanged.
- R12: `irq` is high exactly when (`rx_rdy` and `rx_irq_en`) or (`rx_ovr` and `ovr_irq_en`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_begin | input | 1 | Pulse: address matched with write direction |
| tx_begin | input | 1 | Pulse: address matched with read direction |
| ack_bit | input | 1 | Level driven in receive acknowledge slots (0 = acknowledge) |
| rx_irq_en | input | 1 | Interrupt enable for `rx_rdy` |
| ovr_irq_en | input | 1 | Interrupt enable for `rx_ovr` |
| sw_rd | input | 1 | Pulse: software reads the holding buffer |
| sw_wr | input | 1 | Pulse: software writes the holding buffer |
| sw_wdata | input | DATA_W | Write data for the buffer |
| rd_data | output | DATA_W | Holding buffer contents |
| busy | output | 1 | Byte transfer in progress |
| rx_rdy | output | 1 | Received byte waiting in the buffer |
| rx_ovr | output | 1 | Receive overrun |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check the following on every cycle:
- overrun never exists without a full buffer;
- SDA stays released during overrun reception;
- the target only starts pulling SDA low while synchronized SCL is low;
- `busy` only rises with SCL high;
- the two kinds of buffer read have their stated effects;
- a buffer write during transmission is refused.

The bench scenarios are needed for the ordering-dependent behaviour:
- the bit order of received and transmitted bytes;
- the acknowledge level seen on the wire;
- the release of the held byte after overrun;
- the switch to the next byte after a host acknowledge;
- the quiet bus after a refusal;
- the abort on START with flags preserved.

// File: rtl/i2c_tde_pkg.sv
package i2c_tde_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_BIT,
        ST_RX_ACK,
        ST_TX_BIT,
        ST_TX_ACK
    } tde_state_e;

endpackage

// File: rtl/i2c_tde_linemon.sv
module i2c_tde_linemon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_evt
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] lvl_q;
    logic             cond_start;
    logic             cond_stop;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '1;
        else        lvl_q <= lvl;
    end

    // SCL is line 0, SDA is line 1
    assign scl_lvl    = lvl[0];
    assign sda_lvl    = lvl[1];
    assign scl_rise   = lvl[0] & ~lvl_q[0];
    assign scl_fall   = ~lvl[0] & lvl_q[0];
    assign cond_start = lvl[0] & lvl_q[0] & lvl_q[1] & ~lvl[1];
    assign cond_stop  = lvl[0] & lvl_q[0] & ~lvl_q[1] & lvl[1];
    assign bus_evt    = cond_start | cond_stop;

endmodule

// File: rtl/i2c_tde_fsm.sv
module i2c_tde_fsm
    import i2c_tde_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          bus_evt,
    input  logic          sda_lvl,
    input  logic          start_rx,
    input  logic          start_tx,
    input  logic          ack_bit,
    input  logic          ovr,
    input  logic [DW-1:0] tx_src,
    output logic          sda_oe,
    output logic          busy,
    output logic          rx_mode,
    output logic          tx_mode,
    output logic          byte_done,
    output logic [DW-1:0] shreg_o,
    output logic [DW-1:0] rx_byte
);
    localparam int        CW      = $clog2(DW + 1);
    localparam [CW-1:0]   LAST    = CW'(DW);
    localparam [CW-1:0]   LAST_M1 = CW'(DW - 1);

    tde_state_e      state_q, state_d;
    logic [CW-1:0]   cnt;
    logic [DW-1:0]   shreg;
    logic            busy_q;
    logic            oe_q;
    logic            ack_seen;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_rx)      state_d = ST_RX_BIT;
                else if (start_tx) state_d = ST_TX_BIT;
            end
            ST_RX_BIT: if (scl_fall && cnt == LAST) state_d = ST_RX_ACK;
            ST_RX_ACK: if (scl_fall)                state_d = ST_RX_BIT;
            ST_TX_BIT: if (scl_fall && cnt == LAST) state_d = ST_TX_ACK;
            ST_TX_ACK: if (scl_fall) state_d = ack_seen ? ST_TX_BIT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (bus_evt && state_q != ST_IDLE) state_d = ST_IDLE;
    end

    assign rx_byte = {shreg[DW-2:0], sda_lvl};

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            shreg    <= '0;
            busy_q   <= 1'b0;
            oe_q     <= 1'b0;
            ack_seen <= 1'b0;
        end else if (bus_evt && state_q != ST_IDLE) begin
            cnt    <= '0;
            busy_q <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt    <= '0;
                    busy_q <= 1'b0;
                    oe_q   <= 1'b0;
                    if (!start_rx && start_tx) begin
                        shreg <= tx_src;
                        oe_q  <= ~tx_src[DW-1];
                    end
                end
                ST_RX_BIT: begin
                    if (scl_rise) begin
                        cnt    <= cnt + CW'(1);
                        busy_q <= 1'b1;
                        if (!ovr) shreg <= rx_byte;
                    end
                    if (scl_fall && cnt == LAST) oe_q <= ~ovr & ~ack_bit;
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        oe_q   <= 1'b0;
                        busy_q <= 1'b0;
                        cnt    <= '0;
                    end
                end
                ST_TX_BIT: begin
                    if (scl_rise) begin
                        cnt    <= cnt + CW'(1);
                        busy_q <= 1'b1;
                    end
                    if (scl_fall && cnt != '0) begin
                        if (cnt == LAST) begin
                            oe_q   <= 1'b0;
                            busy_q <= 1'b0;
                        end else begin
                            shreg <= {shreg[DW-2:0], 1'b0};
                            oe_q  <= ~shreg[DW-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) ack_seen <= ~sda_lvl;
                    if (scl_fall) begin
                        cnt <= '0;
                        if (ack_seen) begin
                            shreg <= tx_src;
                            oe_q  <= ~tx_src[DW-1];
                        end else begin
                            oe_q <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe    = oe_q;
    assign busy      = busy_q;
    assign shreg_o   = shreg;
    assign rx_mode   = (state_q == ST_RX_BIT) || (state_q == ST_RX_ACK);
    assign tx_mode   = (state_q == ST_TX_BIT) || (state_q == ST_TX_ACK);
    assign byte_done = (state_q == ST_RX_BIT) && scl_rise && (cnt == LAST_M1) && !bus_evt;

endmodule

// File: rtl/i2c_tde_holdbuf.sv
module i2c_tde_holdbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_done,
    input  logic [DW-1:0] rx_byte,
    input  logic [DW-1:0] shreg,
    input  logic          sw_rd,
    input  logic          sw_wr,
    input  logic [DW-1:0] sw_wdata,
    input  logic          busy,
    output logic [DW-1:0] hold,
    output logic          rx_rdy,
    output logic          rx_ovr
);
    logic buf_free;

    assign buf_free = !rx_rdy || sw_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold   <= '0;
            rx_rdy <= 1'b0;
            rx_ovr <= 1'b0;
        end else begin
            if (sw_rd) begin
                if (rx_ovr) begin
                    hold   <= shreg;
                    rx_rdy <= 1'b1;
                    rx_ovr <= 1'b0;
                end else begin
                    rx_rdy <= 1'b0;
                end
            end
            if (byte_done && !rx_ovr) begin
                if (buf_free) begin
                    hold   <= rx_byte;
                    rx_rdy <= 1'b1;
                end else begin
                    rx_ovr <= 1'b1;
                end
            end
            if (sw_wr && !busy) hold <= sw_wdata;
        end
    end

endmodule

// File: rtl/i2c_target_data_engine.sv
module i2c_target_data_engine #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              rx_begin,
    input  logic              tx_begin,
    input  logic              ack_bit,
    input  logic              rx_irq_en,
    input  logic              ovr_irq_en,
    input  logic              sw_rd,
    input  logic              sw_wr,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              rx_rdy,
    output logic              rx_ovr,
    output logic              irq
);
    logic              scl_lvl;
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              bus_evt;
    logic              rx_mode;
    logic              tx_mode;
    logic              byte_done;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] rx_byte;

    i2c_tde_linemon #(.STAGES(SYNC_STAGES)) u_linemon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_evt  (bus_evt)
    );

    i2c_tde_fsm #(.DW(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_evt   (bus_evt),
        .sda_lvl   (sda_lvl),
        .start_rx  (rx_begin),
        .start_tx  (tx_begin),
        .ack_bit   (ack_bit),
        .ovr       (rx_ovr),
        .tx_src    (rd_data),
        .sda_oe    (sda_oe),
        .busy      (busy),
        .rx_mode   (rx_mode),
        .tx_mode   (tx_mode),
        .byte_done (byte_done),
        .shreg_o   (shreg),
        .rx_byte   (rx_byte)
    );

    i2c_tde_holdbuf #(.DW(DATA_W)) u_holdbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .shreg     (shreg),
        .sw_rd     (sw_rd),
        .sw_wr     (sw_wr),
        .sw_wdata  (sw_wdata),
        .busy      (busy),
        .hold      (rd_data),
        .rx_rdy    (rx_rdy),
        .rx_ovr    (rx_ovr)
    );

    assign irq = (rx_rdy & rx_irq_en) | (rx_ovr & ovr_irq_en);

endmodule

// File: rtl/i2c_tde_checker.sv
module i2c_tde_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_lvl,
    input logic          sda_oe,
    input logic          busy,
    input logic          rx_mode,
    input logic          tx_mode,
    input logic          rx_rdy,
    input logic          rx_ovr,
    input logic          sw_rd,
    input logic          sw_wr,
    input logic [DW-1:0] hold
);
    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |-> rx_rdy); // R5

    AST_OVR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr && rx_mode) |-> !sda_oe); // R6

    AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl); // R8

    AST_BUSY_WITH_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> scl_lvl); // R2

    AST_READ_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rd && rx_rdy && !rx_ovr && !busy) |=> !rx_rdy); // R7

    AST_READ_RELEASES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rd && rx_ovr) |=> (rx_rdy && !rx_ovr)); // R7

    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && busy && tx_mode) |=> $stable(hold)); // R9

endmodule

bind i2c_target_data_engine i2c_tde_checker #(.DW(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_lvl (scl_lvl),
    .sda_oe  (sda_oe),
    .busy    (busy),
    .rx_mode (rx_mode),
    .tx_mode (tx_mode),
    .rx_rdy  (rx_rdy),
    .rx_ovr  (rx_ovr),
    .sw_rd   (sw_rd),
    .sw_wr   (sw_wr),
    .hold    (rd_data)
);

// File: tb/i2c_target_data_engine_tb.sv
module i2c_target_data_engine_tb;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_in, sda_host, sda_in, sda_oe;
    logic       rx_begin, tx_begin, ack_bit, rx_irq_en, ovr_irq_en;
    logic       sw_rd, sw_wr;
    logic [7:0] sw_wdata, rd_data;
    logic       busy, rx_rdy, rx_ovr, irq;

    assign sda_in = sda_host & ~sda_oe;

    i2c_target_data_engine u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .sda_oe(sda_oe),
        .rx_begin(rx_begin), .tx_begin(tx_begin), .ack_bit(ack_bit),
        .rx_irq_en(rx_irq_en), .ovr_irq_en(ovr_irq_en), .sw_rd(sw_rd), .sw_wr(sw_wr),
        .sw_wdata(sw_wdata), .rd_data(rd_data), .busy(busy), .rx_rdy(rx_rdy),
        .rx_ovr(rx_ovr), .irq(irq)
    );

    always #4 clk = ~clk;

    // reference model state
    logic       m_busy, m_rdy, m_ovr, m_oe;
    logic [7:0] m_hold, m_held, m_tx;
    int         cyc = 0, last_chg = 0, checks = 0, errors = 0;
    bit         fin = 1'b0;

    function automatic logic m_irq();
        return (m_rdy && rx_irq_en) || (m_ovr && ovr_irq_en);
    endfunction

    task automatic cmp(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !fin) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // cycle-by-cycle comparison once outputs have settled
    always @(negedge clk) begin
        if (rst_n && !fin && (cyc - last_chg) >= 4) begin
            cmp({7'd0, busy},   {7'd0, m_busy},  "R2 busy");
            cmp({7'd0, rx_rdy}, {7'd0, m_rdy},   "R3 rx_rdy");
            cmp({7'd0, rx_ovr}, {7'd0, m_ovr},   "R5 rx_ovr");
            cmp({7'd0, sda_oe}, {7'd0, m_oe},    "R8 sda_oe");
            cmp({7'd0, irq},    {7'd0, m_irq()}, "R12 irq");
            cmp(rd_data, m_hold, "R3 rd_data");
        end
    end

    task automatic hold_q();
        last_chg = cyc;
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic rd_pulse();
        sw_rd = 1'b1;
        @(posedge clk); #1;
        sw_rd = 1'b0;
        if (m_ovr) begin m_hold = m_held; m_rdy = 1'b1; m_ovr = 1'b0; end
        else m_rdy = 1'b0;
        hold_q();
    endtask

    task automatic wr_pulse(input logic [7:0] d);
        sw_wdata = d; sw_wr = 1'b1;
        @(posedge clk); #1;
        sw_wr = 1'b0;
        if (!m_busy) m_hold = d;
        hold_q();
    endtask

    task automatic rx_byte(input logic [7:0] b);
        logic exp_sda;
        for (int i = 7; i >= 0; i--) begin
            sda_host = b[i]; hold_q();
            scl_in = 1'b1;
            if (i == 7) m_busy = 1'b1;
            if (i == 0 && !m_ovr) begin
                if (m_rdy) begin m_ovr = 1'b1; m_held = b; end
                else begin m_hold = b; m_rdy = 1'b1; end
            end
            hold_q();
            scl_in = 1'b0;
            if (i == 0) m_oe = !m_ovr && !ack_bit;
            hold_q();
        end
        sda_host = 1'b1; hold_q();
        scl_in = 1'b1; hold_q();
        exp_sda = m_ovr ? 1'b1 : ack_bit;
        cmp({7'd0, sda_in}, {7'd0, exp_sda}, m_ovr ? "R6 ack slot" : "R4 ack slot");
        scl_in = 1'b0; m_oe = 1'b0; m_busy = 1'b0; hold_q();
    endtask

    task automatic tx_byte(input bit host_ack, input bit try_lock, input bit nxt_ok,
                           input logic [7:0] nxt);
        for (int i = 7; i >= 0; i--) begin
            cmp({7'd0, sda_in}, {7'd0, m_tx[i]}, "R8 tx bit");
            scl_in = 1'b1;
            if (i == 7) m_busy = 1'b1;
            hold_q();
            if (try_lock && i == 4) begin
                wr_pulse(8'hFF);
                cmp(rd_data, m_hold, "R9 locked write");
            end
            scl_in = 1'b0;
            if (i > 0) m_oe = !m_tx[i-1];
            else begin m_oe = 1'b0; m_busy = 1'b0; end
            hold_q();
        end
        if (nxt_ok) begin
            wr_pulse(nxt);
            cmp(rd_data, nxt, "R9 write after busy");
        end
        sda_host = !host_ack; hold_q();
        scl_in = 1'b1; hold_q();
        scl_in = 1'b0;
        if (host_ack) begin m_tx = m_hold; m_oe = !m_hold[7]; end
        else m_oe = 1'b0;
        hold_q();
        sda_host = 1'b1; hold_q();
    endtask

    initial begin
        rst_n = 1'b0; scl_in = 1'b1; sda_host = 1'b1;
        rx_begin = 1'b0; tx_begin = 1'b0; ack_bit = 1'b0;
        rx_irq_en = 1'b0; ovr_irq_en = 1'b0; sw_rd = 1'b0; sw_wr = 1'b0; sw_wdata = 8'h00;
        m_busy = 1'b0; m_rdy = 1'b0; m_ovr = 1'b0; m_oe = 1'b0;
        m_hold = 8'h00; m_held = 8'h00; m_tx = 8'h00;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        hold_q();
        // R1 reset state
        cmp({4'd0, busy, rx_rdy, rx_ovr, sda_oe}, 8'h00, "R1 flags after reset");
        cmp(rd_data, 8'h00, "R1 buffer after reset");
        cmp({7'd0, irq}, 8'h00, "R1 irq after reset");

        scl_in = 1'b0; hold_q();
        rx_irq_en = 1'b1; ack_bit = 1'b0; hold_q();
        rx_begin = 1'b1; @(posedge clk); #1; rx_begin = 1'b0; hold_q();

        // R2 R3 R4 normal receive
        rx_byte(8'hA5);
        cmp(rd_data, 8'hA5, "R3 received byte");
        cmp({7'd0, irq}, 8'h01, "R12 irq on ready");
        rd_pulse();
        cmp({7'd0, rx_rdy}, 8'h00, "R7 read clears ready");

        ack_bit = 1'b1; hold_q();
        rx_byte(8'h3C);
        cmp({7'd0, rx_rdy}, 8'h01, "R3 ready with refusal level");
        ack_bit = 1'b0; hold_q();

        // R5 overrun
        rx_byte(8'hC3);
        cmp({7'd0, rx_ovr}, 8'h01, "R5 overrun set");
        cmp(rd_data, 8'h3C, "R5 buffer kept");
        rx_irq_en = 1'b0; ovr_irq_en = 1'b1; hold_q();
        cmp({7'd0, irq}, 8'h01, "R12 irq on overrun");

        // R6 byte during overrun
        rx_byte(8'h5A);
        cmp(rd_data, 8'h3C, "R6 ignored byte");

        // R7 release of held byte
        rd_pulse();
        cmp(rd_data, 8'hC3, "R7 held byte released");
        cmp({6'd0, rx_rdy, rx_ovr}, 8'h02, "R7 flags after release");
        rd_pulse();
        rx_byte(8'h81);
        cmp(rd_data, 8'h81, "R7 normal after recovery");

        // R11 abort by START mid-byte
        sda_host = 1'b0; hold_q();
        scl_in = 1'b1; m_busy = 1'b1; hold_q();
        scl_in = 1'b0; hold_q();
        sda_host = 1'b1; hold_q();
        scl_in = 1'b1; hold_q();
        sda_host = 1'b0; m_busy = 1'b0; m_oe = 1'b0; hold_q();
        cmp({7'd0, busy}, 8'h00, "R11 busy cleared");
        cmp({6'd0, rx_rdy, rx_ovr}, 8'h02, "R11 flags kept");
        cmp(rd_data, 8'h81, "R11 buffer kept");
        scl_in = 1'b0; hold_q();
        scl_in = 1'b1; hold_q();
        sda_host = 1'b1; hold_q();
        scl_in = 1'b0; hold_q();
        rd_pulse();

        // R8 R9 R10 transmit
        wr_pulse(8'h96);
        cmp(rd_data, 8'h96, "R9 write while idle");
        tx_begin = 1'b1; @(posedge clk); #1; tx_begin = 1'b0;
        m_tx = m_hold; m_oe = !m_hold[7];
        hold_q();
        tx_byte(1'b1, 1'b1, 1'b1, 8'h4D);
        cmp({7'd0, sda_oe}, {7'd0, !m_tx[7]}, "R10 next byte after acknowledge");
        tx_byte(1'b0, 1'b0, 1'b0, 8'h00);
        scl_in = 1'b1; hold_q();
        cmp({7'd0, sda_oe}, 8'h00, "R10 released after refusal");
        scl_in = 1'b0; hold_q();
        cmp({7'd0, sda_oe}, 8'h00, "R10 idle after refusal");
        sda_host = 1'b0; hold_q();
        scl_in = 1'b1; hold_q();
        sda_host = 1'b1; hold_q();

        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule